// File: doc/BRIEF.md
# Keyed Write Guard for a Sequence Table

This block sits in front of a small table of instruction words and stops writes that were not meant for it. Software reaches the guard over a plain register write bus of enable, address and 32-bit data. Table writes go through only while the guard is unlocked. The block does not hold the table words. It produces a write-permit strobe that the table storage uses as its write enable.

Switching the guard between locked and unlocked takes two bus writes in a row. The first is a fixed 32-bit key written to the key register, which arms the guard. The second is a command written to the control register, with one bit that asks for lock and another that asks for unlock. The guard disarms after any control write. It also disarms after any other bus write, so the command must follow the key with no other write between them. Idle cycles, where the enable is low, do not break the pairing. Three status bits show the locked state, the unlocked state and the armed flag.

Top module: `seq_table_guard`

## Requirements
- R1: After reset the guard is locked and not armed: `guard_status` is 3'b001, `locked_o` is 1 and `tbl_wr_ok` is 0.
- R2: A write of 0x5AF05AF0 to the key register (offset 0x300) sets the armed flag from the next cycle.
- R3: A write of any other value to the key register clears the armed flag.
- R4: A control-register write (offset 0x304) while armed, with data bits [1:0] = 2'b01, locks the guard. With data bits [1:0] = 2'b10 it unlocks the guard. The new state shows from the next cycle.
- R5: A control-register write while not armed leaves the lock state unchanged.
- R6: The armed flag is clear in the cycle after any control-register write, whether or not that write changed the state. This includes data bits [1:0] of 2'b00.
- R7: A control-register write with data bits [1:0] = 2'b11 leaves the lock state unchanged, even when armed.
- R8: Any write to an address other than the key register clears the armed flag. A later control write is then ignored. Cycles with `wr_en` low keep the flag.
- R9: `tbl_wr_ok` is high in the same cycle as a write only when the guard is unlocked and the address lies in the table window. The window runs from 0x310 up to, but not including, 0x310 + 4 × TBL_WORDS, which is 0x410 by default. Otherwise `tbl_wr_ok` is low.
- R10: The bits of `guard_status` are: bit 0 = locked, bit 1 = unlocked, bit 2 = armed. Exactly one of bits 0 and 1 is set, and `locked_o` equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (12) | Byte address of the write |
| wr_data | input | 32 | Write data |
| tbl_wr_ok | output | 1 | Write enable passed to the table storage |
| locked_o | output | 1 | High while table writes are blocked |
| guard_status | output | 3 | {armed, unlocked, locked} |

## Verification
A wrong lock bit appears within one cycle as `tbl_wr_ok` going high or staying low on a table-window write, and as the wrong value on `locked_o`. A stale armed flag never shows on the data path by itself. It shows one cycle after the write that should have cleared it, through status bit 2. It also shows as a control write that takes effect when it should not. The stimulus therefore puts a write just after every key write, covering an idle cycle, a table write, a wrong key and each pattern of the command bits. It reads the status after each of these writes.

// File: rtl/tblguard_pkg.sv
package tblguard_pkg;

  localparam logic [31:0] TG_MAGIC = 32'h5AF0_5AF0;

  localparam int TG_LOCK_BIT   = 0;
  localparam int TG_UNLOCK_BIT = 1;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_KEY   = 3'd1,
    ACC_CTRL  = 3'd2,
    ACC_TABLE = 3'd3,
    ACC_OTHER = 3'd4
  } acc_kind_e;

endpackage

// File: rtl/tg_decode.sv
module tg_decode
  import tblguard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int KEY_OFS   = 'h300,
  parameter int CTRL_OFS  = 'h304,
  parameter int TBL_BASE  = 'h310,
  parameter int TBL_WORDS = 64
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output acc_kind_e         kind
);

  localparam int CMP_W = ADDR_W + 1;
  localparam logic [CMP_W-1:0] TBL_LO = CMP_W'(TBL_BASE);
  localparam logic [CMP_W-1:0] TBL_HI = CMP_W'(TBL_BASE + 4 * TBL_WORDS);

  logic [CMP_W-1:0] addr_ext;
  logic             in_table;

  always_comb begin
    addr_ext = {1'b0, wr_addr};
    in_table = (addr_ext >= TBL_LO) && (addr_ext < TBL_HI);
    if (!wr_en)
      kind = ACC_IDLE;
    else if (wr_addr == ADDR_W'(KEY_OFS))
      kind = ACC_KEY;
    else if (wr_addr == ADDR_W'(CTRL_OFS))
      kind = ACC_CTRL;
    else if (in_table)
      kind = ACC_TABLE;
    else
      kind = ACC_OTHER;
  end

endmodule

// File: rtl/tg_state.sv
module tg_state
  import tblguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  acc_kind_e  kind,
  input  logic [1:0] cmd_bits,
  input  logic       key_match,
  output logic       armed_q,
  output logic       locked_q
);

  logic armed_d, locked_d;
  logic state_en;

  always_comb begin
    armed_d  = armed_q;
    locked_d = locked_q;
    state_en = (kind != ACC_IDLE);
    unique case (kind)
      ACC_KEY:  armed_d = key_match;
      ACC_CTRL: begin
        armed_d = 1'b0;
        if (armed_q) begin
          if (cmd_bits[TG_LOCK_BIT] && !cmd_bits[TG_UNLOCK_BIT])
            locked_d = 1'b1;
          else if (cmd_bits[TG_UNLOCK_BIT] && !cmd_bits[TG_LOCK_BIT])
            locked_d = 1'b0;
        end
      end
      ACC_TABLE, ACC_OTHER: armed_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b1;
    end else if (state_en) begin
      armed_q  <= armed_d;
      locked_q <= locked_d;
    end
  end

endmodule

// File: rtl/seq_table_guard.sv
module seq_table_guard
  import tblguard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int KEY_OFS   = 'h300,
  parameter int CTRL_OFS  = 'h304,
  parameter int TBL_BASE  = 'h310,
  parameter int TBL_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              tbl_wr_ok,
  output logic              locked_o,
  output logic [2:0]        guard_status
);

  acc_kind_e kind;
  logic      armed_q, locked_q;

  tg_decode #(
    .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .CTRL_OFS(CTRL_OFS),
    .TBL_BASE(TBL_BASE), .TBL_WORDS(TBL_WORDS)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .kind   (kind)
  );

  tg_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .cmd_bits (wr_data[1:0]),
    .key_match(wr_data == TG_MAGIC),
    .armed_q  (armed_q),
    .locked_q (locked_q)
  );

  always_comb begin
    tbl_wr_ok    = (kind == ACC_TABLE) && !locked_q;
    locked_o     = locked_q;
    guard_status = {armed_q, !locked_q, locked_q};
  end

endmodule

// File: rtl/seq_table_guard_chk.sv
module seq_table_guard_chk #(
  parameter int ADDR_W   = 12,
  parameter int KEY_OFS  = 'h300,
  parameter int CTRL_OFS = 'h304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              tbl_wr_ok,
  input logic              locked_o,
  input logic [2:0]        guard_status
);

  logic ctrl_wr, key_good;
  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));
  assign key_good = wr_en && (wr_addr == ADDR_W'(KEY_OFS)) && (wr_data == 32'h5AF0_5AF0);

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    key_good |=> guard_status[2]);

  a_r5_unarmed_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !guard_status[2]) |=> $stable(locked_o));

  a_r6_disarm_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !guard_status[2]);

  a_r7_both_bits_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[1:0] == 2'b11) |=> $stable(locked_o));

  a_r9_permit_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_ok |-> (wr_en && !locked_o));

  a_r10_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(guard_status[1:0]) == 1 && locked_o == guard_status[0]);

endmodule

bind seq_table_guard seq_table_guard_chk #(
  .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .CTRL_OFS(CTRL_OFS)
) u_chk (.*);

// File: tb/seq_table_guard_tb_top.sv
module seq_table_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int KEY_A      = 'h300;
  localparam int CTRL_A     = 'h304;
  localparam int TBL_A      = 'h310;
  localparam int WORDS      = 64;
  localparam logic [31:0] MAGIC = 32'h5AF0_5AF0;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              tbl_wr_ok, locked_o;
  logic [2:0]        guard_status;

  int checks = 0;
  int errors = 0;

  bit        q_permit[$];
  logic [2:0] q_status[$];
  string     q_tag[$];

  bit m_locked, m_armed;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_table_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tbl_wr_ok(tbl_wr_ok), .locked_o(locked_o),
    .guard_status(guard_status)
  );

  task automatic drive(input bit we, input int addr, input logic [31:0] data, input string tag);
    bit permit;
    @(negedge clk);
    wr_en   = we;
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    permit  = we && addr >= TBL_A && addr < TBL_A + 4 * WORDS && !m_locked;
    if (we) begin
      if (addr == KEY_A) m_armed = (data == MAGIC);
      else if (addr == CTRL_A) begin
        if (m_armed && data[1:0] == 2'b01) m_locked = 1;
        else if (m_armed && data[1:0] == 2'b10) m_locked = 0;
        m_armed = 0;
      end else m_armed = 0;
    end
    q_permit.push_back(permit);
    q_status.push_back({m_armed, !m_locked, m_locked});
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      bit         ep;
      logic [2:0] es;
      string      t;
      ep = q_permit.pop_front();
      es = q_status.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (tbl_wr_ok !== ep) begin
        errors++;
        $display("FAIL %s permit: actual %b expected %b", t, tbl_wr_ok, ep);
      end
      checks++;
      if (guard_status !== es || locked_o !== es[0]) begin
        errors++;
        $display("FAIL %s status: actual %b/%b expected %b/%b", t, guard_status, locked_o, es, es[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    m_locked = 1; m_armed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (guard_status !== 3'b001 || locked_o !== 1'b1 || tbl_wr_ok !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b/%b/%b expected 001/1/0", guard_status, locked_o, tbl_wr_ok);
    end

    drive(1, TBL_A, 32'h1, "R9 table write while locked");
    drive(1, CTRL_A, 32'h2, "R5 unlock without key");
    drive(1, KEY_A, MAGIC, "R2 good key arms");
    drive(1, CTRL_A, 32'h2, "R4 unlock, R6 disarm");
    drive(1, TBL_A, 32'h5, "R9 first table word");
    drive(1, TBL_A + 4 * WORDS - 4, 32'h6, "R9 last table word");
    drive(1, TBL_A + 4 * WORDS, 32'h7, "R9 past table end");
    drive(1, TBL_A - 4, 32'h8, "R9 below table");
    drive(0, TBL_A, 32'h9, "R9 no strobe");
    drive(1, CTRL_A, 32'h1, "R5 lock without key");
    drive(1, KEY_A, 32'h5AF0_5AF1, "R3 wrong key");
    drive(1, KEY_A, MAGIC, "R2 arm again");
    drive(1, KEY_A, 32'h0, "R3 wrong key disarms");
    drive(1, CTRL_A, 32'h1, "R5 lock after disarm");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(1, CTRL_A, 32'h3, "R7 both bits, R6 disarm");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(1, TBL_A + 8, 32'hA, "R8 table write between");
    drive(1, CTRL_A, 32'h1, "R8 lock ignored");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(1, 'h100, 32'hB, "R8 other address");
    drive(1, CTRL_A, 32'h1, "R8 lock ignored after other");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(0, 0, 32'h0, "R8 idle keeps armed");
    drive(1, CTRL_A, 32'h0, "R6 empty command disarms");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(0, 0, 32'h0, "R8 idle keeps armed");
    drive(1, CTRL_A, 32'h1, "R4 lock");
    drive(1, TBL_A, 32'hC, "R9 blocked after lock");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(1, CTRL_A, 32'h1, "R4 lock while locked");
    drive(1, KEY_A, MAGIC, "R2 arm");
    drive(1, CTRL_A, 32'hFFFF_FFFE, "R4 unlock upper bits set");
    drive(1, TBL_A + 12, 32'hD, "R10 unlocked status");
    drive(0, 0, 32'h0, "R10 drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule